// File: doc/BRIEF.md
# Format-Tagged Streaming Port

This block sits between an external application and three internal byte queues, one for each stream type: asynchronous, plain isochronous and formatted isochronous (such as compressed or digital video). Every byte crossing the port is paired with a 3-bit format code. The code names the stream the byte belongs to and opens, continues or closes a packet. On the write side the port decodes the code, checks that it follows the packet framing, and pushes the byte into the matching queue. On the read side it pops the queue the application selects and returns the byte with the code stored beside it.

All logic runs on the port's own clock. The queues take care of any crossing into the core clock. A 2-bit mode input selects how the data pins behave:
- 8-bit parallel, full duplex.
- 1-bit serial, with bytes carried LSB-first on data bit 0.
- Half-duplex bidirectional, where the two enables act as write and read enables that share one transfer slot.
- No-flow-control output, where the application cannot stall the port and only samples a valid strobe.

Top module: `fsp_port`

## Requirements
- R1: In a flow-controlled write mode, an accepted write with a legal non-idle code raises exactly one bit of `q_push_o` in the same cycle, with `q_push_data_o` equal to the byte and `q_push_fmt_o` equal to the code. The bit index comes from the code:
  - async (001 start, 010 continue) and end marker 111 of an open async packet push bit 0.
  - isochronous (011 start, 100 continue) pushes bit 1.
  - formatted isochronous (101 start, 110 continue) pushes bit 2.
  - end marker 111 pushes the queue of the packet it closes.
- R2: A write carrying code 000 (idle) pushes nothing and leaves the framing state unchanged.
- R3: The following codes are framing errors:
  - a start code while a packet is open;
  - a continue code when no packet is open, or when the open packet is of another stream type;
  - code 111 when no packet is open.
  Such a byte is dropped and `frame_err_o` is set one cycle later and stays set until reset. The open packet is unaffected.
- R4: In modes 00, 01 and 10, a write whose target queue reports full drives `wr_ready_o` low in that cycle. No push happens and the beat is not consumed.
- R5: In mode 11 (no flow control), a write to a full queue keeps `wr_ready_o` high and drops the byte. `overflow_o` is set one cycle later and stays set until reset. The framing state still advances.
- R6: In mode 01 (serial), eight accepted write beats form one byte from `wr_data_i[0]`, LSB first. The byte takes the format code sampled on the first beat, and the push happens on the eighth beat only.
- R7: In mode 00, when `rd_en_i` is high and the queue named by `rd_sel_i` (0 async, 1 isochronous, 2 formatted) is not empty, that queue's `q_pop_o` bit rises in the same cycle. In the next cycle `rd_valid_o` is 1 and `rd_data_o`/`rd_fmt_o` show that queue's head byte and code.
- R8: A read of an empty queue pops nothing. In the next cycle `rd_valid_o` is 0 and `rd_fmt_o` is 000.
- R9: In mode 11, the selected queue is popped whenever it is not empty, with `rd_en_i` low, and the byte is presented with `rd_valid_o` one cycle later.
- R10: In mode 01, the first read beat pops one byte. That beat and the following seven read beats present its bits LSB-first on `rd_data_o[0]`, each with `rd_valid_o` high and the byte's code on `rd_fmt_o`.
- R11: In mode 10, a cycle with both `wr_en_i` and `rd_en_i` high serves the write only: no pop, and `rd_valid_o` is 0 in the next cycle. In mode 00, the same cycle serves both directions.
- R12: After reset:
  - `wr_ready_o` is 1;
  - `rd_valid_o`, `frame_err_o` and `overflow_o` are 0;
  - `rd_fmt_o` is 000;
  - no push or pop is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 2 | 00 parallel, 01 serial, 10 bidirectional, 11 no flow control |
| wr_en_i | input | 1 | Application write beat (write enable in bidirectional mode) |
| wr_data_i | input | 8 | Write byte, or bit 0 only in serial mode |
| wr_fmt_i | input | 3 | Format code of the write beat |
| wr_ready_o | output | 1 | Low when the target queue cannot take the byte |
| rd_en_i | input | 1 | Application read beat (read enable in bidirectional mode) |
| rd_sel_i | input | 2 | Queue to read: 0 async, 1 isochronous, 2 formatted |
| rd_valid_o | output | 1 | Read data valid, sampled on the rising edge |
| rd_data_o | output | 8 | Read byte, or one bit on bit 0 in serial mode |
| rd_fmt_o | output | 3 | Format code of the read byte, 000 when not valid |
| q_full_i | input | 3 | Per-queue full flags |
| q_push_o | output | 3 | Per-queue push strobes |
| q_push_data_o | output | 8 | Byte pushed to the queue |
| q_push_fmt_o | output | 3 | Format code pushed with the byte |
| q_empty_i | input | 3 | Per-queue empty flags |
| q_head_data_i | input | 24 | Head bytes of the queues, queue n at bits 8n+7:8n |
| q_head_fmt_i | input | 9 | Head codes of the queues, queue n at bits 3n+2:3n |
| q_pop_o | output | 3 | Per-queue pop strobes |
| frame_err_o | output | 1 | Sticky framing error |
| overflow_o | output | 1 | Sticky drop flag for the no-flow-control mode |

## Verification
A write and a read can fall in the same cycle, and the mode decides what happens. In bidirectional mode the write wins and the read is refused. In parallel mode both are served. The bench drives both enables together with a non-empty queue and a legal write code in each of these two modes. It judges the result from `q_push_o` and `q_pop_o` in that cycle and from `rd_valid_o` in the next. A second overlap is checked as well: in no-flow-control mode, a full-queue drop and a framing advance happen on the same beat. The bench confirms that the next code in the packet is still accepted.

// File: rtl/fsp_pkg.sv
package fsp_pkg;
    localparam int DATA_W = 8;
    localparam int FMT_W  = 3;
    localparam int NQ     = 3;
    localparam int QSEL_W = 2;

    typedef enum logic [1:0] {
        MODE_PAR    = 2'd0,
        MODE_SER    = 2'd1,
        MODE_BIDIR  = 2'd2,
        MODE_NOFLOW = 2'd3
    } mode_e;

    localparam logic [FMT_W-1:0] CODE_IDLE = 3'd0;
    localparam logic [FMT_W-1:0] CODE_EOP  = 3'd7;

    // odd codes below the end marker open a packet
    function automatic logic code_is_start(input logic [FMT_W-1:0] c);
        return c[0] && (c != CODE_EOP);
    endfunction

    // even non-zero codes continue a packet
    function automatic logic code_is_cont(input logic [FMT_W-1:0] c);
        return !c[0] && (c != CODE_IDLE);
    endfunction

    function automatic logic [QSEL_W-1:0] start_queue(input logic [FMT_W-1:0] c);
        return c[2:1];
    endfunction

    function automatic logic [QSEL_W-1:0] cont_queue(input logic [FMT_W-1:0] c);
        return c[2:1] - 2'd1;
    endfunction
endpackage

// File: rtl/fsp_wr_path.sv
module fsp_wr_path
    import fsp_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int FW = FMT_W,
    parameter int QN = NQ
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    mode_i,
    input  logic          wr_en_i,
    input  logic [DW-1:0] wr_data_i,
    input  logic [FW-1:0] wr_fmt_i,
    output logic          wr_ready_o,
    input  logic [QN-1:0] q_full_i,
    output logic [QN-1:0] q_push_o,
    output logic [DW-1:0] q_push_data_o,
    output logic [FW-1:0] q_push_fmt_o,
    output logic          frame_err_o,
    output logic          overflow_o
);
    localparam int CNT_W = $clog2(DW);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DW - 1);

    typedef struct packed {
        logic              open;
        logic [QSEL_W-1:0] typ;
        logic [CNT_W-1:0]  cnt;
        logic [DW-1:0]     sh;
        logic [FW-1:0]     fmt;
        logic              ferr;
        logic              ovf;
    } wst_t;

    wst_t st_d, st_q;

    logic              ser, nofl, last, legal, psh, full_t, nopen;
    logic [DW-1:0]     asm_v, byte_v;
    logic [FW-1:0]     code;
    logic [QSEL_W-1:0] tgt, ntyp;

    always_comb begin
        st_d       = st_q;
        q_push_o   = '0;
        wr_ready_o = 1'b1;
        ser    = (mode_i == MODE_SER);
        nofl   = (mode_i == MODE_NOFLOW);
        last   = !ser || (st_q.cnt == CNT_LAST);
        asm_v  = st_q.sh;
        asm_v[st_q.cnt] = wr_data_i[0];
        byte_v = ser ? asm_v : wr_data_i;
        code   = (ser && (st_q.cnt != '0)) ? st_q.fmt : wr_fmt_i;
        legal  = 1'b1;
        psh    = 1'b0;
        tgt    = st_q.typ;
        nopen  = st_q.open;
        ntyp   = st_q.typ;
        if (code_is_start(code)) begin
            legal = !st_q.open;
            psh   = 1'b1;
            tgt   = start_queue(code);
            nopen = 1'b1;
            ntyp  = start_queue(code);
        end else if (code_is_cont(code)) begin
            legal = st_q.open && (st_q.typ == cont_queue(code));
            psh   = 1'b1;
            tgt   = cont_queue(code);
        end else if (code == CODE_EOP) begin
            legal = st_q.open;
            psh   = 1'b1;
            nopen = 1'b0;
        end
        full_t = q_full_i[tgt];
        if (last && psh && legal && full_t && !nofl) wr_ready_o = 1'b0;
        if (wr_en_i && wr_ready_o) begin
            if (!last) begin
                st_d.sh  = asm_v;
                st_d.cnt = st_q.cnt + 1'b1;
                if (st_q.cnt == '0) st_d.fmt = wr_fmt_i;
            end else begin
                st_d.cnt = '0;
                st_d.sh  = '0;
                if (psh && !legal) begin
                    st_d.ferr = 1'b1;
                end else if (psh) begin
                    st_d.open = nopen;
                    st_d.typ  = ntyp;
                    if (full_t) st_d.ovf = 1'b1;
                    else        q_push_o[tgt] = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q_push_data_o = byte_v;
    assign q_push_fmt_o  = code;
    assign frame_err_o   = st_q.ferr;
    assign overflow_o    = st_q.ovf;

    // R1: one queue at most per beat
    p_push_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(q_push_o));
    // R4: never push into a full queue
    p_no_push_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (q_push_o & q_full_i) == '0);
    // R4: backpressure only when some queue is full
    p_ready_needs_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ready_o |-> (q_full_i != '0));
    // R3: framing error appears only after a write beat, then stays
    p_ferr_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_err_o ##1 frame_err_o |-> $past(wr_en_i));
    p_ferr_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err_o |=> frame_err_o);
    // R5: drops only occur in the no-flow-control mode, then stay flagged
    p_ovf_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !overflow_o ##1 overflow_o |-> $past(mode_i == MODE_NOFLOW));
    p_ovf_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        overflow_o |=> overflow_o);
endmodule

// File: rtl/fsp_rd_path.sv
module fsp_rd_path
    import fsp_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int FW = FMT_W,
    parameter int QN = NQ
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode_i,
    input  logic             rd_en_i,
    input  logic [QSEL_W-1:0] rd_sel_i,
    input  logic             wr_en_i,
    input  logic [QN-1:0]    q_empty_i,
    input  logic [QN*DW-1:0] q_head_data_i,
    input  logic [QN*FW-1:0] q_head_fmt_i,
    output logic [QN-1:0]    q_pop_o,
    output logic             rd_valid_o,
    output logic [DW-1:0]    rd_data_o,
    output logic [FW-1:0]    rd_fmt_o
);
    localparam int CNT_W = $clog2(DW);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DW - 1);

    typedef struct packed {
        logic             valid;
        logic [DW-1:0]    data;
        logic [FW-1:0]    fmt;
        logic [CNT_W-1:0] cnt;
        logic [DW-1:0]    byte_h;
        logic [FW-1:0]    fmt_h;
    } rst_t;

    rst_t st_d, st_q;

    logic          ser, want, avail;
    logic [DW-1:0] head_d;
    logic [FW-1:0] head_f;

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        st_d.data  = '0;
        st_d.fmt   = '0;
        q_pop_o    = '0;
        ser    = (mode_i == MODE_SER);
        want   = (mode_i == MODE_NOFLOW) ||
                 (rd_en_i && !((mode_i == MODE_BIDIR) && wr_en_i));
        avail  = (int'(rd_sel_i) < QN) && !q_empty_i[rd_sel_i];
        head_d = q_head_data_i[int'(rd_sel_i)*DW +: DW];
        head_f = q_head_fmt_i[int'(rd_sel_i)*FW +: FW];
        if (want) begin
            if (ser && (st_q.cnt != '0)) begin
                st_d.valid = 1'b1;
                st_d.data  = DW'(st_q.byte_h[st_q.cnt]);
                st_d.fmt   = st_q.fmt_h;
                st_d.cnt   = (st_q.cnt == CNT_LAST) ? '0 : st_q.cnt + 1'b1;
            end else if (avail) begin
                q_pop_o[rd_sel_i] = 1'b1;
                st_d.valid = 1'b1;
                st_d.fmt   = head_f;
                if (ser) begin
                    st_d.data   = DW'(head_d[0]);
                    st_d.byte_h = head_d;
                    st_d.fmt_h  = head_f;
                    st_d.cnt    = CNT_W'(1);
                end else begin
                    st_d.data = head_d;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_valid_o = st_q.valid;
    assign rd_data_o  = st_q.data;
    assign rd_fmt_o   = st_q.fmt;

    // R7: one queue popped at most, and each pop yields valid data next cycle
    p_pop_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(q_pop_o));
    p_pop_then_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (q_pop_o != '0) |=> rd_valid_o);
    // R8: empty queues are never popped and idle output carries code 000
    p_no_pop_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (q_pop_o & q_empty_i) == '0);
    p_idle_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid_o |-> (rd_fmt_o == '0));
    // R11: half-duplex collision never pops
    p_bidir_write_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_i == MODE_BIDIR) && wr_en_i && rd_en_i) |-> (q_pop_o == '0));
endmodule

// File: rtl/fsp_port.sv
module fsp_port
    import fsp_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int FW = FMT_W,
    parameter int QN = NQ
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode_i,
    input  logic              wr_en_i,
    input  logic [DW-1:0]     wr_data_i,
    input  logic [FW-1:0]     wr_fmt_i,
    output logic              wr_ready_o,
    input  logic              rd_en_i,
    input  logic [QSEL_W-1:0] rd_sel_i,
    output logic              rd_valid_o,
    output logic [DW-1:0]     rd_data_o,
    output logic [FW-1:0]     rd_fmt_o,
    input  logic [QN-1:0]     q_full_i,
    output logic [QN-1:0]     q_push_o,
    output logic [DW-1:0]     q_push_data_o,
    output logic [FW-1:0]     q_push_fmt_o,
    input  logic [QN-1:0]     q_empty_i,
    input  logic [QN*DW-1:0]  q_head_data_i,
    input  logic [QN*FW-1:0]  q_head_fmt_i,
    output logic [QN-1:0]     q_pop_o,
    output logic              frame_err_o,
    output logic              overflow_o
);
    fsp_wr_path #(.DW(DW), .FW(FW), .QN(QN)) u_wr (
        .clk           (clk),
        .rst_n         (rst_n),
        .mode_i        (mode_i),
        .wr_en_i       (wr_en_i),
        .wr_data_i     (wr_data_i),
        .wr_fmt_i      (wr_fmt_i),
        .wr_ready_o    (wr_ready_o),
        .q_full_i      (q_full_i),
        .q_push_o      (q_push_o),
        .q_push_data_o (q_push_data_o),
        .q_push_fmt_o  (q_push_fmt_o),
        .frame_err_o   (frame_err_o),
        .overflow_o    (overflow_o)
    );

    fsp_rd_path #(.DW(DW), .FW(FW), .QN(QN)) u_rd (
        .clk           (clk),
        .rst_n         (rst_n),
        .mode_i        (mode_i),
        .rd_en_i       (rd_en_i),
        .rd_sel_i      (rd_sel_i),
        .wr_en_i       (wr_en_i),
        .q_empty_i     (q_empty_i),
        .q_head_data_i (q_head_data_i),
        .q_head_fmt_i  (q_head_fmt_i),
        .q_pop_o       (q_pop_o),
        .rd_valid_o    (rd_valid_o),
        .rd_data_o     (rd_data_o),
        .rd_fmt_o      (rd_fmt_o)
    );
endmodule

// File: tb/fsp_port_bench.sv
`timescale 1ns/1ps
module fsp_port_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  mode;
    logic        wr_en, rd_en;
    logic [7:0]  wr_data, rd_data, push_data;
    logic [2:0]  wr_fmt, rd_fmt, push_fmt, full, push, empty, pop;
    logic [1:0]  rd_sel;
    logic        wr_ready, rd_valid, ferr, ovf;
    logic [23:0] head_data;
    logic [8:0]  head_fmt;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    fsp_port u_fsp_port (
        .clk(clk), .rst_n(rst_n), .mode_i(mode),
        .wr_en_i(wr_en), .wr_data_i(wr_data), .wr_fmt_i(wr_fmt), .wr_ready_o(wr_ready),
        .rd_en_i(rd_en), .rd_sel_i(rd_sel), .rd_valid_o(rd_valid), .rd_data_o(rd_data),
        .rd_fmt_o(rd_fmt), .q_full_i(full), .q_push_o(push), .q_push_data_o(push_data),
        .q_push_fmt_o(push_fmt), .q_empty_i(empty), .q_head_data_i(head_data),
        .q_head_fmt_i(head_fmt), .q_pop_o(pop), .frame_err_o(ferr), .overflow_o(ovf)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; mode = 2'd0; wr_en = 1'b0; rd_en = 1'b0;
        wr_data = '0; wr_fmt = '0; rd_sel = '0; full = '0; empty = 3'b111;
        head_data = '0; head_fmt = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
    endtask

    typedef struct packed {
        logic [2:0] fmt;
        logic [7:0] dat;
        logic [2:0] full;
        logic [2:0] push;
        logic       rdy;
        logic       ferr;
    } vec_t;

    // parallel write sequence: code, byte, full flags -> push, ready, sticky error after edge
    localparam vec_t VEC [13] = '{
        '{3'd0, 8'hAA, 3'b000, 3'b000, 1'b1, 1'b0},   // R2 idle
        '{3'd1, 8'h11, 3'b000, 3'b001, 1'b1, 1'b0},   // R1 async start
        '{3'd2, 8'h12, 3'b000, 3'b001, 1'b1, 1'b0},   // R1 async continue
        '{3'd7, 8'h13, 3'b000, 3'b001, 1'b1, 1'b0},   // R1 end of async
        '{3'd3, 8'h21, 3'b000, 3'b010, 1'b1, 1'b0},   // R1 iso start
        '{3'd4, 8'h22, 3'b010, 3'b000, 1'b0, 1'b0},   // R4 iso queue full
        '{3'd4, 8'h22, 3'b000, 3'b010, 1'b1, 1'b0},   // R4 retried
        '{3'd7, 8'h23, 3'b000, 3'b010, 1'b1, 1'b0},   // R1 end of iso
        '{3'd5, 8'h31, 3'b000, 3'b100, 1'b1, 1'b0},   // R1 formatted start
        '{3'd6, 8'h32, 3'b100, 3'b000, 1'b0, 1'b0},   // R4 formatted full
        '{3'd3, 8'h40, 3'b000, 3'b000, 1'b1, 1'b1},   // R3 start while open
        '{3'd6, 8'h32, 3'b000, 3'b100, 1'b1, 1'b1},   // R3 packet survives error
        '{3'd7, 8'h33, 3'b000, 3'b100, 1'b1, 1'b1}    // R3 sticky
    };

    localparam logic [7:0] SER_BYTE = 8'hA5;
    localparam logic [7:0] RD_BYTE  = 8'h96;

    initial begin
        do_reset();
        #2;
        // R12 reset state
        chk("R12 ready", wr_ready, 1);
        chk("R12 valid", rd_valid, 0);
        chk("R12 fmt", rd_fmt, 0);
        chk("R12 ferr", ferr, 0);
        chk("R12 ovf", ovf, 0);
        chk("R12 push", push, 0);
        chk("R12 pop", pop, 0);

        // table walk, mode 00
        foreach (VEC[i]) begin
            @(negedge clk);
            wr_en = 1'b1; wr_fmt = VEC[i].fmt; wr_data = VEC[i].dat; full = VEC[i].full;
            #2;
            chk($sformatf("R1/R4 push row %0d", i), push, VEC[i].push);
            chk($sformatf("R4 ready row %0d", i), wr_ready, VEC[i].rdy);
            if (VEC[i].push != 0) begin
                chk($sformatf("R1 data row %0d", i), push_data, VEC[i].dat);
                chk($sformatf("R1 code row %0d", i), push_fmt, VEC[i].fmt);
            end
            @(posedge clk); #1;
            chk($sformatf("R3 ferr row %0d", i), ferr, VEC[i].ferr);
        end
        @(negedge clk); wr_en = 1'b0; full = '0;

        // R3 continue with no open packet
        do_reset();
        wr_en = 1'b1; wr_fmt = 3'd4; wr_data = 8'h50;
        #2 chk("R3 orphan continue no push", push, 0);
        @(posedge clk); #1 chk("R3 orphan continue flag", ferr, 1);
        @(negedge clk); wr_en = 1'b0;

        // R6 serial write of A5, code 001 on first beat only
        do_reset();
        mode = 2'd1;
        for (int b = 0; b < 8; b++) begin
            @(negedge clk);
            wr_en = 1'b1; wr_data = {7'h55, SER_BYTE[b]}; wr_fmt = (b == 0) ? 3'd1 : 3'd6;
            #2;
            if (b < 7) chk("R6 no push mid byte", push, 0);
            else begin
                chk("R6 push queue", push, 3'b001);
                chk("R6 byte", push_data, SER_BYTE);
                chk("R6 code", push_fmt, 3'd1);
            end
        end
        @(negedge clk); wr_en = 1'b0;
        #2 chk("R6 ferr clear", ferr, 0);

        // R5 no-flow-control drop, framing still advances
        do_reset();
        mode = 2'd3; wr_en = 1'b1; wr_fmt = 3'd3; wr_data = 8'h70; full = 3'b010;
        #2;
        chk("R5 ready high", wr_ready, 1);
        chk("R5 dropped", push, 0);
        @(posedge clk); #1 chk("R5 overflow", ovf, 1);
        @(negedge clk); wr_fmt = 3'd4; wr_data = 8'h71; full = '0;
        #2 chk("R5 packet still open", push, 3'b010);
        @(posedge clk); #1;
        chk("R5 sticky", ovf, 1);
        chk("R5 no framing error", ferr, 0);
        @(negedge clk); wr_en = 1'b0;

        // R7 parallel read of queue 1
        do_reset();
        empty = 3'b000;
        head_data = {8'h99, 8'h5C, 8'h33};
        head_fmt  = {3'd6, 3'd4, 3'd2};
        rd_sel = 2'd1; rd_en = 1'b1;
        #2 chk("R7 pop", pop, 3'b010);
        @(posedge clk); #1;
        chk("R7 valid", rd_valid, 1);
        chk("R7 data", rd_data, 8'h5C);
        chk("R7 fmt", rd_fmt, 3'd4);

        // R8 empty read
        @(negedge clk); empty = 3'b010;
        #2 chk("R8 no pop", pop, 0);
        @(posedge clk); #1;
        chk("R8 valid low", rd_valid, 0);
        chk("R8 fmt idle", rd_fmt, 0);
        @(negedge clk); rd_en = 1'b0; empty = 3'b000;

        // R9 no-flow-control read without enable
        mode = 2'd3; rd_sel = 2'd2;
        #2 chk("R9 pop", pop, 3'b100);
        @(posedge clk); #1;
        chk("R9 valid", rd_valid, 1);
        chk("R9 data", rd_data, 8'h99);
        chk("R9 fmt", rd_fmt, 3'd6);

        // R10 serial read of 96 from queue 0
        do_reset();
        mode = 2'd1; empty = 3'b000; rd_sel = 2'd0;
        head_data = {8'h00, 8'h00, RD_BYTE}; head_fmt = {3'd0, 3'd0, 3'd1};
        for (int b = 0; b < 8; b++) begin
            @(negedge clk); rd_en = 1'b1;
            #2 chk("R10 pop beat", pop, (b == 0) ? 3'b001 : 3'b000);
            @(posedge clk); #1;
            chk("R10 valid", rd_valid, 1);
            chk("R10 bit", rd_data, {7'b0, RD_BYTE[b]});
            chk("R10 fmt", rd_fmt, 3'd1);
        end
        @(negedge clk); rd_en = 1'b0;

        // R11 bidirectional collision, then parallel full duplex
        do_reset();
        mode = 2'd2; empty = 3'b000; rd_sel = 2'd1;
        head_data = {8'h00, 8'h42, 8'h00}; head_fmt = {3'd0, 3'd4, 3'd0};
        wr_en = 1'b1; rd_en = 1'b1; wr_fmt = 3'd1; wr_data = 8'h61;
        #2;
        chk("R11 write served", push, 3'b001);
        chk("R11 read refused", pop, 0);
        @(posedge clk); #1 chk("R11 no valid", rd_valid, 0);
        @(negedge clk); wr_en = 1'b0;
        #2 chk("R11 read alone", pop, 3'b010);
        @(negedge clk); mode = 2'd0; wr_en = 1'b1; wr_fmt = 3'd2; wr_data = 8'h62;
        #2;
        chk("R11 duplex write", push, 3'b001);
        chk("R11 duplex read", pop, 3'b010);
        @(posedge clk); #1 chk("R11 duplex valid", rd_valid, 1);
        @(negedge clk); wr_en = 1'b0; rd_en = 1'b0;

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule